// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches a stream of bus write cycles, each an address and a data word, and turns them into flash memory commands. Most commands are guarded by an unlock prefix: two fixed writes to two magic addresses, followed by a command code at the first magic address. The magic addresses depend on whether the bus runs in byte or word mode. The decoder also tracks the current operating mode: plain read, identification (auto-select), fast-program bypass, or erase-suspended.

Each recognised command produces a one-cycle strobe with a command kind code. The strobe also carries the address and data of the write that completed the command, so a program operation gets its target address and data and a block erase gets its block address. Two busy inputs from the operation engine limit what gets decoded. While a program runs, every write is ignored. While an erase runs, only suspend and reset are recognised. A write that breaks a sequence returns the decoder to its base read state without any strobe.

The decoder does not access the array, generate status or time the erase windows. A neighbouring engine consumes the strobes and drives the busy and error inputs.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read) and `cmd_valid` is 0.
- R2: In word mode (`byte_mode`=0) the unlock prefix is AA at address 555, then 55 at 2AA, then the code at 555. Only `wr_addr[10:0]` is compared. In byte mode the addresses are AAA, 555 and AAA, and only `wr_addr[11:0]` is compared. Only `wr_data[7:0]` is compared as a code. Modes are encoded as 0 read, 1 auto-select, 2 bypass, 3 suspend.
- R3: Prefix plus code 90 gives a strobe of kind 2 and sets mode 1. This is not accepted in suspend mode.
- R4: A single F0 write at any address while no sequence is open, or F0 as the third prefix write, gives kind 1. The mode becomes 0, except that suspend mode stays 3.
- R5: Prefix plus A0, then one more write, gives kind 3 on that fourth write, with `cmd_addr`/`cmd_data` equal to its address and data.
- R6: Prefix plus 80, then a second prefix, completes an erase. A final 10 at the first magic address gives kind 6 (chip erase). A final 30 at any address gives kind 7 (block erase), with `cmd_addr` set to that write's address. Both set mode 0. Neither is accepted in suspend mode.
- R7: Prefix plus code 20 gives kind 4 and sets mode 2. In mode 2, A0 at any address followed by any write gives kind 3 with that write's address and data, and mode stays 2.
- R8: In mode 2, 90 followed by 00 gives kind 5 and sets mode 0.
- R9: Any write that is not a valid next step of a sequence produces no strobe. It sets mode 0, or leaves mode 3 when suspended.
- R10: While `busy_prog`=1, writes produce no strobe and change neither the mode nor an open sequence.
- R11: While `busy_erase`=1 (and `busy_prog`=0), only B0 (kind 8, mode becomes 3) and F0 (kind 1) at any address are decoded. All other writes produce no strobe and leave the mode and sequence unchanged.
- R12: In mode 3, a single 30 write at any address gives kind 9 and sets mode 0. The four-write program sequence gives kind 3 and leaves mode 3.
- R13: In mode 2, F0 with `op_error`=1 gives kind 1 and keeps mode 2. F0 with `op_error`=0 is malformed and sets mode 0.
- R14: A strobe appears exactly in the cycle after the write that completes a command and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | One bus write cycle this clock |
| wr_addr | input | ADDR_W | Write address (byte address in byte mode) |
| wr_data | input | DATA_W | Write data |
| byte_mode | input | 1 | 1 selects 8-bit bus unlock addresses |
| busy_prog | input | 1 | Program operation running |
| busy_erase | input | 1 | Erase operation running |
| op_error | input | 1 | Engine reports a failed operation |
| mode | output | 2 | Current mode (0 read, 1 auto-select, 2 bypass, 3 suspend) |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 4 | 1 reset, 2 auto-select, 3 program, 4 bypass enter, 5 bypass exit, 6 chip erase, 7 block erase, 8 suspend, 9 resume |
| cmd_addr | output | ADDR_W | Address of the completing write |
| cmd_data | output | DATA_W | Data of the completing write |

## Verification
The bench builds the decoder with ADDR_W=14 and DATA_W=16. With that width, the don't-care address bits above the compared field are few enough to sweep every value of them in both bus modes. The full 256-value space of the third prefix code is swept in word mode, and the same space is swept as a single write under erase-busy. The expected strobe and mode for every code follow arithmetically from the requirement table. Malformed sequences are injected at every one of the six erase positions.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_BYPASS  = 2'd2,
    MODE_SUSPEND = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    K_NONE        = 4'd0,
    K_RESET       = 4'd1,
    K_AUTOSEL     = 4'd2,
    K_PROGRAM     = 4'd3,
    K_BYP_ENTER   = 4'd4,
    K_BYP_EXIT    = 4'd5,
    K_CHIP_ERASE  = 4'd6,
    K_BLOCK_ERASE = 4'd7,
    K_SUSPEND     = 4'd8,
    K_RESUME      = 4'd9
  } kind_e;

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_UNL1  = 4'd1,
    S_UNL2  = 4'd2,
    S_PGM   = 4'd3,
    S_ERS1  = 4'd4,
    S_ERS2  = 4'd5,
    S_ERS3  = 4'd6,
    S_BPGM  = 4'd7,
    S_BEXIT = 4'd8
  } seq_e;

  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] C_KEY1    = 8'hAA;
  localparam logic [CODE_W-1:0] C_KEY2    = 8'h55;
  localparam logic [CODE_W-1:0] C_RESET   = 8'hF0;
  localparam logic [CODE_W-1:0] C_AUTOSEL = 8'h90;
  localparam logic [CODE_W-1:0] C_PROGRAM = 8'hA0;
  localparam logic [CODE_W-1:0] C_BYPASS  = 8'h20;
  localparam logic [CODE_W-1:0] C_ERASE   = 8'h80;
  localparam logic [CODE_W-1:0] C_CHIP    = 8'h10;
  localparam logic [CODE_W-1:0] C_BLOCK   = 8'h30;
  localparam logic [CODE_W-1:0] C_SUSPEND = 8'hB0;
  localparam logic [CODE_W-1:0] C_RESUME  = 8'h30;
  localparam logic [CODE_W-1:0] C_BEXIT   = 8'h00;

  // compared address field widths and magic addresses per bus mode
  localparam int WORD_CMP_W = 11;
  localparam int BYTE_CMP_W = 12;
  localparam logic [WORD_CMP_W-1:0] WORD_PRI = 11'h555;
  localparam logic [WORD_CMP_W-1:0] WORD_SEC = 11'h2AA;
  localparam logic [BYTE_CMP_W-1:0] BYTE_PRI = 12'hAAA;
  localparam logic [BYTE_CMP_W-1:0] BYTE_SEC = 12'h555;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [BYTE_CMP_W-1:0] addr_lo,
  input  logic                  byte_mode,
  output logic                  at_pri,
  output logic                  at_sec
);

  logic word_pri, word_sec, byte_pri, byte_sec;

  always_comb begin
    word_pri = (addr_lo[WORD_CMP_W-1:0] == WORD_PRI);
    word_sec = (addr_lo[WORD_CMP_W-1:0] == WORD_SEC);
    byte_pri = (addr_lo == BYTE_PRI);
    byte_sec = (addr_lo == BYTE_SEC);
    at_pri   = byte_mode ? byte_pri : word_pri;
    at_sec   = byte_mode ? byte_sec : word_sec;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              at_pri,
  input  logic              at_sec,
  input  logic [CODE_W-1:0] code,
  input  mode_e             mode,
  input  logic              busy_prog,
  input  logic              busy_erase,
  input  logic              op_error,
  output kind_e             ev_kind,
  output logic              ev_fall
);

  seq_e st_q, st_nx;
  logic take;
  logic suspended;

  always_comb begin
    take      = wr_valid && !busy_prog;
    suspended = (mode == MODE_SUSPEND);
    st_nx     = st_q;
    ev_kind   = K_NONE;
    ev_fall   = 1'b0;
    if (take && busy_erase) begin
      if (code == C_SUSPEND) begin
        ev_kind = K_SUSPEND;
        st_nx   = S_IDLE;
      end else if (code == C_RESET) begin
        ev_kind = K_RESET;
        st_nx   = S_IDLE;
      end
    end else if (take) begin
      st_nx = S_IDLE;
      unique case (st_q)
        S_IDLE: begin
          if (mode == MODE_BYPASS) begin
            if (code == C_PROGRAM)                st_nx   = S_BPGM;
            else if (code == C_AUTOSEL)           st_nx   = S_BEXIT;
            else if (code == C_RESET && op_error) ev_kind = K_RESET;
            else                                  ev_fall = 1'b1;
          end else if (code == C_RESET) begin
            ev_kind = K_RESET;
          end else if (suspended && code == C_RESUME) begin
            ev_kind = K_RESUME;
          end else if (at_pri && code == C_KEY1) begin
            st_nx = S_UNL1;
          end else begin
            ev_fall = 1'b1;
          end
        end
        S_UNL1: begin
          if (at_sec && code == C_KEY2) st_nx = S_UNL2;
          else ev_fall = 1'b1;
        end
        S_UNL2: begin
          if (!at_pri) ev_fall = 1'b1;
          else begin
            case (code)
              C_RESET:   ev_kind = K_RESET;
              C_PROGRAM: st_nx   = S_PGM;
              C_AUTOSEL: if (suspended) ev_fall = 1'b1; else ev_kind = K_AUTOSEL;
              C_BYPASS:  if (suspended) ev_fall = 1'b1; else ev_kind = K_BYP_ENTER;
              C_ERASE:   if (suspended) ev_fall = 1'b1; else st_nx = S_ERS1;
              default:   ev_fall = 1'b1;
            endcase
          end
        end
        S_PGM:  ev_kind = K_PROGRAM;
        S_ERS1: begin
          if (at_pri && code == C_KEY1) st_nx = S_ERS2;
          else ev_fall = 1'b1;
        end
        S_ERS2: begin
          if (at_sec && code == C_KEY2) st_nx = S_ERS3;
          else ev_fall = 1'b1;
        end
        S_ERS3: begin
          if (code == C_BLOCK)                 ev_kind = K_BLOCK_ERASE;
          else if (at_pri && code == C_CHIP)   ev_kind = K_CHIP_ERASE;
          else                                 ev_fall = 1'b1;
        end
        S_BPGM:  ev_kind = K_PROGRAM;
        S_BEXIT: begin
          if (code == C_BEXIT) ev_kind = K_BYP_EXIT;
          else ev_fall = 1'b1;
        end
        default: ev_fall = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else if (wr_valid) st_q <= st_nx;
  end

  AST_PROG_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && busy_prog |=> $stable(st_q)); // R10

  AST_ERASE_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && busy_erase && !busy_prog && code != C_SUSPEND && code != C_RESET
    |=> $stable(st_q)); // R11

endmodule

// File: rtl/flash_cmd_mode.sv
module flash_cmd_mode
  import flash_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  kind_e ev_kind,
  input  logic  ev_fall,
  input  logic  op_error,
  output mode_e mode_q
);

  mode_e mode_nx;
  logic  mode_en;
  mode_e base_mode;

  always_comb begin
    base_mode = (mode_q == MODE_SUSPEND) ? MODE_SUSPEND : MODE_READ;
    mode_en   = ev_fall || (ev_kind != K_NONE);
    mode_nx   = mode_q;
    if (ev_fall) begin
      mode_nx = base_mode;
    end else begin
      case (ev_kind)
        K_RESET:       mode_nx = (mode_q == MODE_BYPASS && op_error) ? MODE_BYPASS : base_mode;
        K_AUTOSEL:     mode_nx = MODE_AUTOSEL;
        K_BYP_ENTER:   mode_nx = MODE_BYPASS;
        K_BYP_EXIT:    mode_nx = MODE_READ;
        K_PROGRAM:     mode_nx = (mode_q == MODE_BYPASS) ? MODE_BYPASS : base_mode;
        K_CHIP_ERASE:  mode_nx = MODE_READ;
        K_BLOCK_ERASE: mode_nx = MODE_READ;
        K_SUSPEND:     mode_nx = MODE_SUSPEND;
        K_RESUME:      mode_nx = MODE_READ;
        default:       mode_nx = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_READ;
    else if (mode_en) mode_q <= mode_nx;
  end

  AST_BYP_EXIT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_kind == K_BYP_EXIT |=> mode_q == MODE_READ); // R8

  AST_SUSPEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MODE_SUSPEND && ev_fall |=> mode_q == MODE_SUSPEND); // R9

endmodule

// File: rtl/flash_cmd_out.sv
module flash_cmd_out
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  kind_e             ev_kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_valid,
  output kind_e             cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  logic ev_valid;

  always_comb ev_valid = (ev_kind != K_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_valid <= 1'b0;
    else        cmd_valid <= ev_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_kind <= K_NONE;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else if (ev_valid) begin
      cmd_kind <= ev_kind;
      cmd_addr <= wr_addr;
      cmd_data <= wr_data;
    end
  end

  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(cmd_addr) && $stable(cmd_data)); // R14

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              byte_mode,
  input  logic              busy_prog,
  input  logic              busy_erase,
  input  logic              op_error,
  output logic [1:0]        mode,
  output logic              cmd_valid,
  output logic [3:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_i_n;
  logic              at_pri, at_sec;
  kind_e             ev_kind;
  logic              ev_fall;
  mode_e             mode_q;
  kind_e             kind_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_i_n = rst_pipe[SYNC_N-1];

  flash_cmd_match u_match (
    .addr_lo  (wr_addr[BYTE_CMP_W-1:0]),
    .byte_mode(byte_mode),
    .at_pri   (at_pri),
    .at_sec   (at_sec)
  );

  flash_cmd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_valid  (wr_valid),
    .at_pri    (at_pri),
    .at_sec    (at_sec),
    .code      (wr_data[CODE_W-1:0]),
    .mode      (mode_q),
    .busy_prog (busy_prog),
    .busy_erase(busy_erase),
    .op_error  (op_error),
    .ev_kind   (ev_kind),
    .ev_fall   (ev_fall)
  );

  flash_cmd_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ev_kind (ev_kind),
    .ev_fall (ev_fall),
    .op_error(op_error),
    .mode_q  (mode_q)
  );

  flash_cmd_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ev_kind  (ev_kind),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmd_valid(cmd_valid),
    .cmd_kind (kind_q),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data)
  );

  assign mode     = mode_q;
  assign cmd_kind = kind_q;

  AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmd_valid |-> $past(wr_valid)); // R14

  AST_PROG_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_valid && busy_prog |=> !cmd_valid && $stable(mode)); // R10

  AST_ERASE_BUSY_FILTER: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_valid && busy_erase && !busy_prog
    |=> !cmd_valid || kind_q == K_SUSPEND || kind_q == K_RESET); // R11

  AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(mode == MODE_BYPASS) |-> cmd_valid && kind_q == K_BYP_ENTER); // R7

  AST_SUSPEND_MODE: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmd_valid && kind_q == K_SUSPEND |-> mode == MODE_SUSPEND); // R11

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

  localparam int AW = 14;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          byte_mode;
  logic          busy_prog;
  logic          busy_erase;
  logic          op_error;
  logic [1:0]    mode;
  logic          cmd_valid;
  logic [3:0]    cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .byte_mode(byte_mode), .busy_prog(busy_prog),
    .busy_erase(busy_erase), .op_error(op_error), .mode(mode),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data)
  );

  function automatic logic [AW-1:0] pri(input bit bm);
    return bm ? 14'hAAA : 14'h555;
  endfunction
  function automatic logic [AW-1:0] sec(input bit bm);
    return bm ? 14'h555 : 14'h2AA;
  endfunction

  // called at a negedge; returns at the next negedge after checking
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit ev, input int ek, input int em, input string tag);
    bit ok;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    n_tests++;
    ok = (cmd_valid == ev) && (mode == em[1:0]);
    if (ev) ok = ok && (cmd_kind == ek[3:0]) && (cmd_addr == a) && (cmd_data == d);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got v=%0b k=%0d m=%0d a=%h d=%h exp v=%0b k=%0d m=%0d a=%h d=%h",
               tag, cmd_valid, cmd_kind, mode, cmd_addr, cmd_data, ev, ek, em, a, d);
    end
  endtask

  task automatic idle_chk(input int em, input string tag);
    @(negedge clk);
    n_tests++;
    if (cmd_valid !== 1'b0 || mode != em[1:0]) begin
      n_fail++;
      $display("FAIL %s: got v=%0b m=%0d exp v=0 m=%0d", tag, cmd_valid, mode, em);
    end
  endtask

  task automatic prefix(input bit bm, input logic [AW-1:0] up, input logic [DW-1:0] du,
                        input int em, input string tag);
    wr(pri(bm) | up, 16'h00AA | du, 0, 0, em, tag);
    wr(sec(bm) | up, 16'h0055 | du, 0, 0, em, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    byte_mode = 1'b0; busy_prog = 1'b0; busy_erase = 1'b0; op_error = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    idle_chk(0, "R1 reset state");

    // R3 R4 R5 R7 R9: full sweep of the third prefix code in word mode
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cc;
      cc = 8'(c);
      prefix(0, '0, '0, 0, "R9 sweep prefix");
      if (cc == 8'h90) begin
        wr(14'h555, {8'h00, cc}, 1, 2, 1, "R3 autosel");
        wr(14'h0, 16'hF0, 1, 1, 0, "R4 reset from autosel");
      end else if (cc == 8'hA0) begin
        wr(14'h555, {8'h00, cc}, 0, 0, 0, "R5 program armed");
        wr(14'h0, 16'hF0, 1, 3, 0, "R5 program fourth write");
      end else if (cc == 8'h20) begin
        wr(14'h555, {8'h00, cc}, 1, 4, 2, "R7 bypass enter");
        wr(14'h0, 16'hF0, 0, 0, 0, "R13 F0 in bypass without error");
      end else if (cc == 8'h80) begin
        wr(14'h555, {8'h00, cc}, 0, 0, 0, "R6 erase armed");
        wr(14'h0, 16'hF0, 0, 0, 0, "R9 F0 breaks erase prefix");
      end else if (cc == 8'hF0) begin
        wr(14'h555, {8'h00, cc}, 1, 1, 0, "R4 three-write reset");
        wr(14'h0, 16'hF0, 1, 1, 0, "R4 single reset");
      end else begin
        wr(14'h555, {8'h00, cc}, 0, 0, 0, "R9 unknown code");
        wr(14'h0, 16'hF0, 1, 1, 0, "R4 single reset after fallback");
      end
      wr(14'h3FFF, 16'hFFF0, 1, 1, 0, "R4 reset any address, upper data ignored");
    end

    // R2: both bus modes, every don't-care upper address value
    for (int bm = 0; bm < 2; bm++) begin
      byte_mode = bm[0];
      for (int u = 0; u < 8; u++) begin
        logic [AW-1:0] up;
        logic [DW-1:0] du;
        if (bm == 1 && u >= 4) continue;
        up = (bm == 1) ? AW'(u << 12) : AW'(u << 11);
        du = DW'(u * 16'h1100);
        prefix(bm[0], up, du, 0, "R2 prefix");
        wr(pri(bm[0]) | up, 16'h0090 | du, 1, 2, 1, "R2 autosel with don't-care bits");
        wr(14'h0, 16'hF0, 1, 1, 0, "R2 reset");
      end
      // the other mode's addresses must not unlock
      wr(pri(!bm[0]), 16'hAA, 0, 0, 0, "R2 wrong-mode first address");
      wr(sec(!bm[0]), 16'h55, 0, 0, 0, "R2 wrong-mode second address");
      wr(pri(!bm[0]), 16'h90, 0, 0, 0, "R2 wrong-mode code");
    end

    // R5 program in byte mode
    byte_mode = 1'b1;
    prefix(1, '0, '0, 0, "R5 prefix");
    wr(14'hAAA, 16'hA0, 0, 0, 0, "R5 program code");
    wr(14'h1234, 16'hBEEF, 1, 3, 0, "R5 program address and data");
    idle_chk(0, "R14 strobe lasts one cycle");

    // R6 chip and block erase in both modes
    for (int bm = 0; bm < 2; bm++) begin
      byte_mode = bm[0];
      prefix(bm[0], '0, '0, 0, "R6 prefix");
      wr(pri(bm[0]), 16'h80, 0, 0, 0, "R6 erase code");
      prefix(bm[0], '0, '0, 0, "R6 second prefix");
      wr(pri(bm[0]), 16'h10, 1, 6, 0, "R6 chip erase");
      prefix(bm[0], '0, '0, 0, "R6 prefix");
      wr(pri(bm[0]), 16'h80, 0, 0, 0, "R6 erase code");
      prefix(bm[0], '0, '0, 0, "R6 second prefix");
      wr(14'h3000, 16'h30, 1, 7, 0, "R6 block erase address");
      prefix(bm[0], '0, '0, 0, "R6 prefix");
      wr(pri(bm[0]), 16'h80, 0, 0, 0, "R6 erase code");
      prefix(bm[0], '0, '0, 0, "R6 second prefix");
      wr(14'h0001, 16'h10, 0, 0, 0, "R6 chip code off address rejected");
      // R9 corruption at each of the six erase positions
      for (int pos = 0; pos < 6; pos++) begin
        logic [AW-1:0] aseq [6];
        logic [DW-1:0] dseq [6];
        aseq = '{pri(bm[0]), sec(bm[0]), pri(bm[0]), pri(bm[0]), sec(bm[0]), pri(bm[0])};
        dseq = '{16'hAA, 16'h55, 16'h80, 16'hAA, 16'h55, 16'h10};
        for (int k = 0; k < pos; k++) wr(aseq[k], dseq[k], 0, 0, 0, "R9 erase partial");
        wr(aseq[pos], 16'h77, 0, 0, 0, "R9 erase corrupted");
        wr(14'h0, 16'hF0, 1, 1, 0, "R9 idle after corruption");
      end
    end

    // R7 R8 R13 bypass mode
    byte_mode = 1'b0;
    prefix(0, '0, '0, 0, "R7 prefix");
    wr(14'h555, 16'h20, 1, 4, 2, "R7 bypass enter");
    for (int i = 0; i < 8; i++) begin
      wr(14'h2222, 16'hA0, 0, 0, 2, "R7 bypass program code any address");
      wr(AW'(i * 14'h0731), DW'(i * 16'h1357), 1, 3, 2, "R7 bypass program");
    end
    op_error = 1'b1;
    wr(14'h0, 16'hF0, 1, 1, 2, "R13 reset with error stays bypass");
    op_error = 1'b0;
    wr(14'h0, 16'h90, 0, 0, 2, "R8 exit armed");
    wr(14'h0, 16'h00, 1, 5, 0, "R8 bypass exit");
    prefix(0, '0, '0, 0, "R7 prefix");
    wr(14'h555, 16'h20, 1, 4, 2, "R7 bypass enter");
    wr(14'h0, 16'h90, 0, 0, 2, "R8 exit armed");
    wr(14'h0, 16'h01, 0, 0, 0, "R9 bad exit data");
    prefix(0, '0, '0, 0, "R7 prefix");
    wr(14'h555, 16'h20, 1, 4, 2, "R7 bypass enter");
    wr(14'h555, 16'hAA, 0, 0, 0, "R9 prefix not accepted in bypass");

    // R10 busy program freezes everything
    prefix(0, '0, '0, 0, "R10 prefix");
    busy_prog = 1'b1;
    wr(14'h0, 16'hF0, 0, 0, 0, "R10 F0 ignored");
    wr(14'h0, 16'hB0, 0, 0, 0, "R10 B0 ignored");
    wr(14'h555, 16'h20, 0, 0, 0, "R10 code ignored");
    busy_prog = 1'b0;
    wr(14'h555, 16'h90, 1, 2, 1, "R10 open sequence survived");
    wr(14'h0, 16'hF0, 1, 1, 0, "R10 reset");

    // R11 busy erase: sweep every single-write code
    for (int c = 0; c < 256; c++) begin
      busy_erase = 1'b1;
      if (c == 8'hB0) begin
        wr(14'h3FFF, DW'(c), 1, 8, 3, "R11 suspend");
        busy_erase = 1'b0;
        wr(14'h1111, 16'h30, 1, 9, 0, "R12 resume");
      end else if (c == 8'hF0) begin
        wr(14'h3FFF, DW'(c), 1, 1, 0, "R11 reset during erase");
      end else begin
        wr(14'h3FFF, DW'(c), 0, 0, 0, "R11 other codes ignored");
      end
    end
    busy_erase = 1'b1;
    wr(14'h555, 16'hAA, 0, 0, 0, "R11 first key ignored");
    busy_erase = 1'b0;
    wr(14'h2AA, 16'h55, 0, 0, 0, "R11 second key without first breaks");
    wr(14'h555, 16'h90, 0, 0, 0, "R11 code after broken prefix");

    // R12 suspend mode
    busy_erase = 1'b1;
    wr(14'h0, 16'hB0, 1, 8, 3, "R11 suspend");
    busy_erase = 1'b0;
    prefix(0, '0, '0, 3, "R12 prefix");
    wr(14'h555, 16'hA0, 0, 0, 3, "R12 program code");
    wr(14'h0ABC, 16'h5A5A, 1, 3, 3, "R12 program while suspended");
    wr(14'h0, 16'hF0, 1, 1, 3, "R4 reset keeps suspend");
    wr(14'h0, 16'h77, 0, 0, 3, "R9 malformed keeps suspend");
    prefix(0, '0, '0, 3, "R12 prefix");
    wr(14'h555, 16'h90, 0, 0, 3, "R3 autosel refused while suspended");
    prefix(0, '0, '0, 3, "R12 prefix");
    wr(14'h555, 16'h80, 0, 0, 3, "R6 erase refused while suspended");
    wr(14'h2345, 16'h30, 1, 9, 0, "R12 resume");
    idle_chk(0, "R14 no strobe without write");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule